// File: doc/BRIEF.md
# Trap Return State Commit Unit

This unit applies the architectural side effects of a machine-level or supervisor-level trap return once the instruction has been judged legal upstream. It keeps the interrupt-enable and previous-mode fields of the machine status word, the saved-virtualization bit of the hypervisor status word, the current privilege level and the virtualization-mode bit. A one-cycle return strobe, with a kind select, commits the whole new state on one clock edge. On the following cycle the unit presents the resume address, taken from the matching exception-PC register.

When the hypervisor option is built in, a return can move the hart into or out of virtualized mode. The unit then emits a one-cycle request so that neighbouring logic can exchange its banked hypervisor registers. The supervisor return takes one of two paths. Outside virtualization, it also restores the saved virtualization mode and clears the saved bit. Inside virtualization, or without the hypervisor option, it leaves the virtualization mode alone. A plain load port sets up every held field and both exception PCs.

Top module: `trap_return_unit`

## Requirements
- R1: After synchronous reset, priv_o is 2'b11 (machine), virt_o is 0, status_o is all zero, and next_pc_valid and bank_swap are 0. Privilege codes are user 2'b00, supervisor 2'b01 and machine 2'b11.
- R2: The status vector is packed as follows: bit0 SIE, bit1 SPIE, bit2 SPP, bit3 MIE, bit4 MPIE, bits6:5 MPP, bit7 MPV, bit8 SPV. When cfg_we is high, all held fields and both exception PCs load at the clock edge. A load takes priority over a return strobe in the same cycle, and that strobe is then dropped with no PC pulse and no swap.
- R3: A machine return (ret_valid with ret_is_mret=1) copies the old MPIE into MIE, sets MPIE to 1, clears MPP to user and clears MPV. The supervisor fields and SPV are unchanged.
- R4: A machine return sets the privilege to the old MPP value.
- R5: With the hypervisor option, a machine return sets virt_o to the old MPV and pulses bank_swap when virt_o changes.
- R6: With the hypervisor option and virt_o=0, a supervisor return sets the privilege to supervisor if the old SPP is 1 and to user otherwise. It sets virt_o to the old SPV, clears SPV and SPP, copies SPIE into SIE and sets SPIE to 1. It pulses bank_swap when virt_o changes.
- R7: In any other case, a supervisor return sets the privilege from SPP as in R6, copies SPIE into SIE, sets SPIE to 1 and sets SPP to 0. It leaves virt_o and SPV unchanged and does not raise bank_swap.
- R8: In the cycle after an accepted return, next_pc_valid is 1 for exactly one cycle. During that cycle next_pc carries the machine exception PC for a machine return and the supervisor exception PC for a supervisor return.
- R9: bank_swap is a one-cycle pulse in the cycle after an accepted return and is never raised otherwise.
- R10: Without the hypervisor option, a machine return leaves virt_o unchanged and bank_swap is never raised.
- R11: In a cycle with neither cfg_we nor ret_valid, status_o, priv_o and virt_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load strobe for the setup port |
| cfg_status | input | 9 | Status fields to load (layout as R2) |
| cfg_priv | input | 2 | Privilege to load |
| cfg_virt | input | 1 | Virtualization mode to load |
| cfg_mepc | input | XLEN | Machine exception PC to load |
| cfg_sepc | input | XLEN | Supervisor exception PC to load |
| ret_valid | input | 1 | One-cycle return strobe |
| ret_is_mret | input | 1 | 1 = machine return, 0 = supervisor return |
| status_o | output | 9 | Current status fields |
| priv_o | output | 2 | Current privilege |
| virt_o | output | 1 | Current virtualization mode |
| next_pc_valid | output | 1 | Resume address valid pulse |
| next_pc | output | XLEN | Resume address |
| bank_swap | output | 1 | Request to exchange hypervisor register banks |

## Verification
The bench targets supervisor returns whose saved SPV differs from the current mode. A design that takes the wrong branch on virt_o would either leave the mode stuck or lose SPV, and it would also pulse bank_swap at the wrong time. A machine return with MPV set is run against a build without the hypervisor option, where a design that ignores the option would wrongly switch mode. Back-to-back returns expose a design that reads fields already overwritten by the first return, for example restoring MIE from an MPIE that has just been forced to 1. A load coinciding with a return catches a design that lets the strobe slip through.

// File: rtl/trapret_pkg.sv
package trapret_pkg;

    localparam int STAT_W = 9;

    typedef enum logic [1:0] {
        PRIV_USER  = 2'b00,
        PRIV_SUPER = 2'b01,
        PRIV_MACH  = 2'b11
    } priv_e;

    typedef enum logic {
        RET_SUPER = 1'b0,
        RET_MACH  = 1'b1
    } ret_kind_e;

    typedef struct packed {
        logic       spv;
        logic       mpv;
        logic [1:0] mpp;
        logic       mpie;
        logic       mie;
        logic       spp;
        logic       spie;
        logic       sie;
    } stat_t;

    typedef struct packed {
        stat_t      st;
        logic [1:0] priv;
        logic       virt;
    } arch_t;

    localparam arch_t ARCH_RESET = '{st: '0, priv: PRIV_MACH, virt: 1'b0};

    function automatic logic [1:0] spp_to_priv(input logic spp);
        return spp ? PRIV_SUPER : PRIV_USER;
    endfunction

    function automatic arch_t mret_next(input arch_t c, input logic hyp);
        arch_t n;
        n         = c;
        n.st.mie  = c.st.mpie;
        n.st.mpie = 1'b1;
        n.st.mpp  = PRIV_USER;
        n.st.mpv  = 1'b0;
        n.priv    = c.st.mpp;
        if (hyp) n.virt = c.st.mpv;
        return n;
    endfunction

    function automatic arch_t sret_next(input arch_t c, input logic hyp);
        arch_t n;
        n         = c;
        n.st.sie  = c.st.spie;
        n.st.spie = 1'b1;
        n.st.spp  = 1'b0;
        n.priv    = spp_to_priv(c.st.spp);
        if (hyp && !c.virt) begin
            n.st.spv = 1'b0;
            n.virt   = c.st.spv;
        end
        return n;
    endfunction

endpackage

// File: rtl/trapret_next.sv
module trapret_next
    import trapret_pkg::*;
#(
    parameter bit HYP_PRESENT = 1'b1
) (
    input  arch_t     cur,
    input  ret_kind_e kind,
    output arch_t     nxt,
    output logic      swap
);
    arch_t m_nxt, s_nxt;

    generate
        if (HYP_PRESENT) begin : g_hyp
            assign m_nxt = mret_next(cur, 1'b1);
            assign s_nxt = sret_next(cur, 1'b1);
        end else begin : g_nohyp
            assign m_nxt = mret_next(cur, 1'b0);
            assign s_nxt = sret_next(cur, 1'b0);
        end
    endgenerate

    always_comb begin
        case (kind)
            RET_MACH: nxt = m_nxt;
            default:  nxt = s_nxt;
        endcase
        swap = (nxt.virt != cur.virt);
    end
endmodule

// File: rtl/trapret_epc.sv
module trapret_epc
    import trapret_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_we,
    input  logic [XLEN-1:0] cfg_mepc,
    input  logic [XLEN-1:0] cfg_sepc,
    input  logic            take,
    input  ret_kind_e       kind,
    output logic [XLEN-1:0] pc_o,
    output logic            pc_valid_o
);
    logic [XLEN-1:0] mepc_q, sepc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mepc_q     <= '0;
            sepc_q     <= '0;
            pc_o       <= '0;
            pc_valid_o <= 1'b0;
        end else begin
            pc_valid_o <= 1'b0;
            if (cfg_we) begin
                mepc_q <= cfg_mepc;
                sepc_q <= cfg_sepc;
            end else if (take) begin
                pc_o       <= (kind == RET_MACH) ? mepc_q : sepc_q;
                pc_valid_o <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/trap_return_unit.sv
module trap_return_unit
    import trapret_pkg::*;
#(
    parameter int XLEN        = 64,
    parameter bit HYP_PRESENT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [STAT_W-1:0] cfg_status,
    input  logic [1:0]        cfg_priv,
    input  logic              cfg_virt,
    input  logic [XLEN-1:0]   cfg_mepc,
    input  logic [XLEN-1:0]   cfg_sepc,
    input  logic              ret_valid,
    input  logic              ret_is_mret,
    output logic [STAT_W-1:0] status_o,
    output logic [1:0]        priv_o,
    output logic              virt_o,
    output logic              next_pc_valid,
    output logic [XLEN-1:0]   next_pc,
    output logic              bank_swap
);
    arch_t     cur_q, nxt;
    logic      swap_n, swap_q, accept;
    ret_kind_e kind;

    assign kind   = ret_kind_e'(ret_is_mret);
    assign accept = ret_valid & ~cfg_we;

    trapret_next #(.HYP_PRESENT(HYP_PRESENT)) u_next (
        .cur  (cur_q),
        .kind (kind),
        .nxt  (nxt),
        .swap (swap_n)
    );

    trapret_epc #(.XLEN(XLEN)) u_epc (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_mepc   (cfg_mepc),
        .cfg_sepc   (cfg_sepc),
        .take       (accept),
        .kind       (kind),
        .pc_o       (next_pc),
        .pc_valid_o (next_pc_valid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= ARCH_RESET;
            swap_q <= 1'b0;
        end else begin
            swap_q <= 1'b0;
            if (cfg_we) begin
                cur_q <= '{st: stat_t'(cfg_status), priv: cfg_priv, virt: cfg_virt};
            end else if (accept) begin
                cur_q  <= nxt;
                swap_q <= swap_n;
            end
        end
    end

    assign status_o  = cur_q.st;
    assign priv_o    = cur_q.priv;
    assign virt_o    = cur_q.virt;
    assign bank_swap = swap_q;

    // R3
    mret_fields_chk: assert property (@(posedge clk) disable iff (rst)
        accept && ret_is_mret |=> status_o[4] && status_o[6:5] == 2'b00 && !status_o[7]
                                   && status_o[3] == $past(status_o[4]));
    // R4
    mret_priv_chk: assert property (@(posedge clk) disable iff (rst)
        accept && ret_is_mret |=> priv_o == $past(status_o[6:5]));
    // R7
    sret_fields_chk: assert property (@(posedge clk) disable iff (rst)
        accept && !ret_is_mret |=> status_o[1] && !status_o[2] && status_o[0] == $past(status_o[1]));
    // R8
    pc_origin_chk: assert property (@(posedge clk) disable iff (rst)
        next_pc_valid |-> $past(accept));
    // R8
    pc_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> next_pc_valid);
    // R9
    swap_origin_chk: assert property (@(posedge clk) disable iff (rst)
        bank_swap |-> $past(accept) && virt_o != $past(virt_o));
    // R11
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_we && !ret_valid |=> $stable(status_o) && $stable(priv_o) && $stable(virt_o));

    generate
        if (!HYP_PRESENT) begin : g_nohyp_chk
            // R10
            nohyp_virt_chk: assert property (@(posedge clk) disable iff (rst)
                accept |=> virt_o == $past(virt_o));
        end
    endgenerate
endmodule

// File: tb/trap_return_unit_bench.sv
module trap_return_unit_bench;
    localparam int XLEN = 64;

    logic            clk = 1'b0;
    logic            rst;
    logic            cfg_we, cfg_virt, ret_valid, ret_is_mret;
    logic [8:0]      cfg_status;
    logic [1:0]      cfg_priv;
    logic [XLEN-1:0] cfg_mepc, cfg_sepc;

    logic [8:0]      st_h, st_n;
    logic [1:0]      pr_h, pr_n;
    logic            v_h, v_n, pv_h, pv_n, sw_h, sw_n;
    logic [XLEN-1:0] pc_h, pc_n;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    trap_return_unit #(.XLEN(XLEN), .HYP_PRESENT(1'b1)) u_trap_return_unit (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_status(cfg_status), .cfg_priv(cfg_priv),
        .cfg_virt(cfg_virt), .cfg_mepc(cfg_mepc), .cfg_sepc(cfg_sepc), .ret_valid(ret_valid),
        .ret_is_mret(ret_is_mret), .status_o(st_h), .priv_o(pr_h), .virt_o(v_h),
        .next_pc_valid(pv_h), .next_pc(pc_h), .bank_swap(sw_h));

    trap_return_unit #(.XLEN(XLEN), .HYP_PRESENT(1'b0)) u_nohyp (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_status(cfg_status), .cfg_priv(cfg_priv),
        .cfg_virt(cfg_virt), .cfg_mepc(cfg_mepc), .cfg_sepc(cfg_sepc), .ret_valid(ret_valid),
        .ret_is_mret(ret_is_mret), .status_o(st_n), .priv_o(pr_n), .virt_o(v_n),
        .next_pc_valid(pv_n), .next_pc(pc_n), .bank_swap(sw_n));

    // reference state per instance
    logic [8:0]      es_h, es_n;
    logic [1:0]      ep_h, ep_n;
    logic            ev_h, ev_n;
    logic [XLEN-1:0] emepc, esepc;

    task automatic chk(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    function automatic void model(input bit hyp, input bit m, input logic [8:0] s, input logic [1:0] p,
                                  input logic v, output logic [8:0] ns, output logic [1:0] np,
                                  output logic nv, output logic sw);
        ns = s; np = p; nv = v;
        if (m) begin
            ns[3] = s[4]; ns[4] = 1'b1; ns[6:5] = 2'b00; ns[7] = 1'b0;
            np = s[6:5];
            if (hyp) nv = s[7];
        end else begin
            ns[0] = s[1]; ns[1] = 1'b1; ns[2] = 1'b0;
            np = s[2] ? 2'b01 : 2'b00;
            if (hyp && !v) begin ns[8] = 1'b0; nv = s[8]; end
        end
        sw = (nv != v);
    endfunction

    task automatic check_state(input string req);
        chk(req, "status", 64'(st_h), 64'(es_h));
        chk(req, "priv",   64'(pr_h), 64'(ep_h));
        chk(req, "virt",   64'(v_h),  64'(ev_h));
        chk(req, "nohyp status", 64'(st_n), 64'(es_n));
        chk(req, "nohyp priv",   64'(pr_n), 64'(ep_n));
        chk(req, "nohyp virt",   64'(v_n),  64'(ev_n));
    endtask

    task automatic load(input logic [8:0] s, input logic [1:0] p, input logic v,
                        input logic [XLEN-1:0] me, input logic [XLEN-1:0] se);
        cfg_we = 1'b1; cfg_status = s; cfg_priv = p; cfg_virt = v; cfg_mepc = me; cfg_sepc = se;
        @(negedge clk);
        cfg_we = 1'b0;
        es_h = s; es_n = s; ep_h = p; ep_n = p; ev_h = v; ev_n = v; emepc = me; esepc = se;
        check_state("R2");
    endtask

    task automatic do_ret(input bit m, input string req);
        logic esw_h, esw_n;
        logic [8:0] s1; logic [1:0] p1; logic v1;
        ret_valid = 1'b1; ret_is_mret = m;
        model(1'b1, m, es_h, ep_h, ev_h, s1, p1, v1, esw_h);
        es_h = s1; ep_h = p1; ev_h = v1;
        model(1'b0, m, es_n, ep_n, ev_n, s1, p1, v1, esw_n);
        es_n = s1; ep_n = p1; ev_n = v1;
        @(negedge clk);
        ret_valid = 1'b0;
        check_state(req);
        chk("R8", "pc_valid", 64'(pv_h), 64'd1);
        chk("R8", "next_pc", pc_h, m ? emepc : esepc);
        chk("R8", "nohyp next_pc", pc_n, m ? emepc : esepc);
        chk("R9", "swap", 64'(sw_h), 64'(esw_h));
        chk("R10", "nohyp swap", 64'(sw_n), 64'(esw_n));
    endtask

    task automatic idle_check();
        @(negedge clk);
        chk("R8", "pc_valid drop", 64'(pv_h), 64'd0);
        chk("R9", "swap drop", 64'(sw_h), 64'd0);
        check_state("R11");
    endtask

    function automatic logic [1:0] rnd_priv();
        int r = int'($urandom % 3);
        return (r == 2) ? 2'b11 : 2'(r);
    endfunction

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        rst = 1'b1; cfg_we = 0; ret_valid = 0; ret_is_mret = 0;
        cfg_status = '0; cfg_priv = '0; cfg_virt = 0; cfg_mepc = '0; cfg_sepc = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "priv", 64'(pr_h), 64'h3);
        chk("R1", "virt", 64'(v_h), 64'h0);
        chk("R1", "status", 64'(st_h), 64'h0);
        chk("R1", "pc_valid", 64'(pv_h), 64'h0);
        chk("R1", "swap", 64'(sw_h), 64'h0);
        es_h = '0; es_n = '0; ep_h = 2'b11; ep_n = 2'b11; ev_h = 0; ev_n = 0; emepc = '0; esepc = '0;

        // R5 machine return entering virtualization (MPV=1, MPP=S, MPIE=1)
        load(9'b0_1_01_1_0_0_0_0, 2'b11, 1'b0, 64'h8000_0000_0000_1000, 64'h4000);
        do_ret(1'b1, "R5");
        idle_check();
        // R7 supervisor return while virtualized, SPV=0, SPP=1, SPIE=1
        load(9'b0_0_00_0_0_1_1_0, 2'b01, 1'b1, 64'h100, 64'h2222_0000);
        do_ret(1'b0, "R7");
        idle_check();
        // R6 supervisor return, V=0, SPV=1 -> enter virtualization
        load(9'b1_0_00_0_0_0_1_0, 2'b01, 1'b0, 64'h100, 64'h3330);
        do_ret(1'b0, "R6");
        idle_check();
        // R3 R4 back-to-back returns read only old fields
        load(9'b0_0_11_0_1_1_0_1, 2'b11, 1'b0, 64'hABC0, 64'hDEF0);
        do_ret(1'b1, "R3");
        do_ret(1'b1, "R4");
        do_ret(1'b0, "R6");
        idle_check();
        // R2 load beats a simultaneous return
        cfg_we = 1'b1; ret_valid = 1'b1; ret_is_mret = 1'b1;
        cfg_status = 9'h0A5; cfg_priv = 2'b01; cfg_virt = 1'b1; cfg_mepc = 64'h55; cfg_sepc = 64'h66;
        @(negedge clk);
        cfg_we = 1'b0; ret_valid = 1'b0;
        es_h = 9'h0A5; es_n = 9'h0A5; ep_h = 2'b01; ep_n = 2'b01; ev_h = 1; ev_n = 1;
        emepc = 64'h55; esepc = 64'h66;
        check_state("R2");
        chk("R2", "no pc pulse", 64'(pv_h), 64'd0);
        chk("R2", "no swap", 64'(sw_h), 64'd0);
        idle_check();

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [8:0] s;
            s = 9'($urandom);
            s[6:5] = rnd_priv();
            load(s, rnd_priv(), 1'($urandom), {$urandom, $urandom}, {$urandom, $urandom});
            for (int k = 0; k < 1 + int'($urandom % 3); k++) begin
                if ($urandom % 2 == 1) do_ret(1'b1, "R3");
                else                   do_ret(1'b0, "R7");
            end
            idle_check();
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule